// File: doc/BRIEF.md
# Receive Packet Buffer with Overflow Policy

This block takes packets from the switch side of a management bridge and parks each one in an on-chip buffer until the local processor has read it. The link delivers 16-bit words with a valid strobe and flags for the first word, the last word, and a last word that carries only one byte. The first accepted word opens the buffer. When the last word is taken in, the block records the packet's byte count in a small status window, sets a packet-received cause bit, and drives the interrupt line.

The buffer then stays occupied until the processor writes an explicit release. While it is occupied, a configuration input decides what happens when another packet arrives. In flow-control mode the block raises a hold signal toward the link, so the sender waits. In discard mode the block swallows every incoming packet whole and counts it. The link never stalls in discard mode, so only this channel loses traffic.

The processor reaches the buffer and the status words through a simple read/write port. The read data is registered.

Top module: `rx_pkt_buffer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), irq and lnk_hold are 0, and reads of 0x9E4, 0x9E6, 0x9E8 and 0x9F0 return 0.
- R2: Each word of an accepted packet is stored in order. Word k sits at byte offset 2k and can be read at byte addresses 0x000 to 0x7FF, with address bit 0 ignored. cpu_rdata shows a read in the cycle after cpu_rd is sampled.
- R3: When the last word is accepted, the byte count becomes 2 × (words) − lnk_odd, where lnk_odd is sampled on the last word. The count reads at 0x9E4 until the next end-of-packet.
- R4: The clock edge that accepts a last word sets the cause bit, and irq follows that bit. A read of 0x9F0 returns the bit in bit 0 and clears it.
- R5: The buffer is held from the end-of-packet edge until a write of exactly 0x0001 to 0x9F2. While held, bit 0 of 0x9E8 reads 1. A release written while filling, or a write of any other value, has no effect.
- R6: With cfg_drop = 0, lnk_hold is 1 exactly while the buffer is held.
- R7: With cfg_drop = 1, lnk_hold stays 0. A packet whose first word arrives while the buffer is held is dropped whole, and the stored data and byte count are left unchanged.
- R8: The drop counter at 0x9E6 goes up by one for each packet dropped in discard mode.
- R9: Once a packet is being dropped, its remaining words are discarded even if the buffer is released part-way through it. The next packet with a first flag is accepted.
- R10: Words past the 1024-word capacity are not stored. A truncated packet reports a byte count of 2048.
- R11: Reads of any other address (0x800 to 0x9E3, 0x9EA to 0x9EF, 0x9F1 and above) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lnk_vld | input | 1 | A link word is present |
| lnk_first | input | 1 | The word is the first word of a packet |
| lnk_last | input | 1 | The word is the last word of a packet |
| lnk_odd | input | 1 | The last word carries only one byte |
| lnk_data | input | 16 | Link word |
| lnk_hold | output | 1 | Flow-control hold toward the link |
| cfg_drop | input | 1 | 1 = discard while occupied, 0 = flow control |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | 12 | Processor byte address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Read data, one cycle after cpu_rd |
| irq | output | 1 | Packet-received interrupt |

## Verification
The assertions assume the link frames its packets correctly. A packet starts with a word flagged first, ends with a word flagged last, and a new first word is never sent while a packet is still being filled. They also assume the link obeys lnk_hold in flow-control mode. The stimulus keeps to these rules: it sends whole packets one after another, and it switches into discard mode before offering traffic to a held buffer. Processor reads go only to buffer locations that a packet has already written, because the buffer's contents are undefined after reset.

// File: rtl/rxpb_pkg.sv
// Package rxpb_pkg
// Shared constants and types for the receive packet buffer: the register
// window addresses the processor sees, and the fill-state encoding.
// Assumes 16-bit link words and a 16-bit processor data path.
package rxpb_pkg;
    localparam int unsigned DATA_W = 16;

    // Processor-visible register window (byte addresses)
    localparam logic [11:0] A_BYTES   = 12'h9E4;
    localparam logic [11:0] A_DROPS   = 12'h9E6;
    localparam logic [11:0] A_FLAGS   = 12'h9E8;
    localparam logic [11:0] A_CAUSE   = 12'h9F0;
    localparam logic [11:0] A_RELEASE = 12'h9F2;
    localparam logic [15:0] REL_KEY   = 16'h0001;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_FILL = 2'd1,
        FR_HELD = 2'd2
    } fr_state_e;
endpackage

// File: rtl/rxpb_store.sv
// Module rxpb_store
// Single-port-write, single-port-read word memory that holds the packet.
// The read is synchronous and happens only when re is high, so rdata keeps
// its value between reads. A read and a write to the same word in one cycle
// return the old data. The memory itself is not reset.
module rxpb_store #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned DW    = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    // Write a link word into the packet memory.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read port, updated only on a processor read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/rxpb_frame.sv
// Module rxpb_frame
// Write side of the buffer. It accepts a packet from the link, tracks the
// fill position, captures the byte count at end-of-packet, and applies the
// overflow policy while the buffer is held: a hold toward the link, or
// discard with a drop counter.
// Assumes the link sends well-framed packets (no first flag while filling).
module rxpb_frame
    import rxpb_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 2048,
    parameter int unsigned DROP_W    = 16,
    localparam int unsigned WORDS    = BUF_BYTES / 2,
    localparam int unsigned WPTR_W   = $clog2(WORDS),
    localparam int unsigned CNT_W    = $clog2(WORDS + 1),
    localparam int unsigned BYTE_W   = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lnk_vld,
    input  logic              lnk_first,
    input  logic              lnk_last,
    input  logic              lnk_odd,
    input  logic [DATA_W-1:0] lnk_data,
    input  logic              drop_en,
    input  logic              rel_req,
    output logic              mem_we,
    output logic [WPTR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              eop_evt,
    output logic              held,
    output logic              hold,
    output logic [BYTE_W-1:0] byte_cnt,
    output logic [DROP_W-1:0] drop_cnt
);
    fr_state_e         state_q;
    logic [CNT_W-1:0]  wcnt_q;
    logic              trunc_q;
    logic              dropping_q;
    logic [BYTE_W-1:0] bytes_q;
    logic [DROP_W-1:0] drops_q;

    logic              is_idle, is_fill, is_held;
    logic              accept, room, trunc_now, start_drop;
    logic [CNT_W-1:0]  base_cnt, next_cnt;
    logic [BYTE_W-1:0] eop_bytes;

    // Decode the state, accept rule, write position and end-of-packet count.
    always_comb begin
        is_idle    = (state_q == FR_IDLE);
        is_fill    = (state_q == FR_FILL);
        is_held    = (state_q == FR_HELD);
        accept     = lnk_vld && !dropping_q && ((is_idle && lnk_first) || is_fill);
        base_cnt   = is_idle ? '0 : wcnt_q;
        room       = (base_cnt < CNT_W'(WORDS));
        trunc_now  = (is_fill && trunc_q) || !room;
        next_cnt   = room ? (base_cnt + 1'b1) : base_cnt;
        eop_bytes  = trunc_now ? BYTE_W'(BUF_BYTES)
                               : ({next_cnt, 1'b0} - BYTE_W'(lnk_odd));
        start_drop = lnk_vld && lnk_first && is_held && drop_en && !dropping_q;
    end

    // Fill-state sequencing: idle -> fill -> held -> idle on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
        end else if (accept && lnk_last) begin
            state_q <= FR_HELD;
        end else if (accept) begin
            state_q <= FR_FILL;
        end else if (is_held && rel_req) begin
            state_q <= FR_IDLE;
        end
    end

    // Word position and truncation flag of the packet being filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q  <= '0;
            trunc_q <= 1'b0;
        end else if (accept) begin
            wcnt_q  <= next_cnt;
            trunc_q <= trunc_now;
        end
    end

    // Capture the byte count at end-of-packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_q <= '0;
        end else if (accept && lnk_last) begin
            bytes_q <= eop_bytes;
        end
    end

    // Discard tracking: swallow a dropped packet up to its last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dropping_q <= 1'b0;
        end else if (start_drop) begin
            dropping_q <= !lnk_last;
        end else if (dropping_q && lnk_vld && lnk_last) begin
            dropping_q <= 1'b0;
        end
    end

    // Count each packet dropped while the buffer is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drops_q <= '0;
        end else if (start_drop) begin
            drops_q <= drops_q + 1'b1;
        end
    end

    assign mem_we    = accept && room;
    assign mem_waddr = base_cnt[WPTR_W-1:0];
    assign mem_wdata = lnk_data;
    assign eop_evt   = accept && lnk_last;
    assign held      = is_held;
    assign hold      = is_held && !drop_en;
    assign byte_cnt  = bytes_q;
    assign drop_cnt  = drops_q;

    // R5: a release while held frees the buffer on the next edge
    a_r5_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (is_held && rel_req) |=> (state_q == FR_IDLE));

    // R5: without a release the buffer stays held
    a_r5_stays_held: assert property (@(posedge clk) disable iff (!rst_n)
        (is_held && !rel_req) |=> (state_q == FR_HELD));

    // R3: the captured count does not move while the buffer is held
    a_r3_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
        is_held |=> $stable(bytes_q));

    // R8: each dropped packet adds exactly one to the counter
    a_r8_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        start_drop |=> (drops_q == $past(drops_q) + 1'b1));

    // R10: the fill position never passes the capacity
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_q <= CNT_W'(WORDS));
endmodule

// File: rtl/rxpb_cpu_port.sv
// Module rxpb_cpu_port
// Processor side. It decodes reads of the buffer and the status window,
// registers the read data, keeps the clear-on-read cause bit that drives
// the interrupt, and decodes the release write.
// Assumes one access per cycle and a fixed one-cycle read latency.
module rxpb_cpu_port
    import rxpb_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 2048,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DROP_W    = 16,
    localparam int unsigned WORDS    = BUF_BYTES / 2,
    localparam int unsigned WPTR_W   = $clog2(WORDS),
    localparam int unsigned BYTE_W   = $clog2(WORDS + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              eop_evt,
    input  logic              held,
    input  logic [BYTE_W-1:0] byte_cnt,
    input  logic [DROP_W-1:0] drop_cnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_re,
    output logic [WPTR_W-1:0] mem_raddr,
    output logic              rel_req,
    output logic              irq,
    output logic [DATA_W-1:0] cpu_rdata
);
    logic              cause_q;
    logic              sel_buf_q;
    logic [DATA_W-1:0] reg_q;
    logic [DATA_W-1:0] reg_val;
    logic              in_buf;
    logic              rd_cause;

    // Select the status word addressed by the processor.
    always_comb begin
        in_buf   = (cpu_addr < ADDR_W'(BUF_BYTES));
        rd_cause = cpu_rd && (cpu_addr == ADDR_W'(A_CAUSE));
        reg_val  = '0;
        case (cpu_addr)
            ADDR_W'(A_BYTES): reg_val = DATA_W'(byte_cnt);
            ADDR_W'(A_DROPS): reg_val = DATA_W'(drop_cnt);
            ADDR_W'(A_FLAGS): reg_val = {{(DATA_W-1){1'b0}}, held};
            ADDR_W'(A_CAUSE): reg_val = {{(DATA_W-1){1'b0}}, cause_q};
            default:          reg_val = '0;
        endcase
    end

    // Register the read source and the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_buf_q <= 1'b0;
            reg_q     <= '0;
        end else if (cpu_rd) begin
            sel_buf_q <= in_buf;
            reg_q     <= reg_val;
        end
    end

    // Cause bit: set by end-of-packet, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= 1'b0;
        end else if (eop_evt) begin
            cause_q <= 1'b1;
        end else if (rd_cause) begin
            cause_q <= 1'b0;
        end
    end

    assign mem_re    = cpu_rd && in_buf;
    assign mem_raddr = cpu_addr[WPTR_W:1];
    assign rel_req   = cpu_wr && (cpu_addr == ADDR_W'(A_RELEASE)) && (cpu_wdata == REL_KEY);
    assign irq       = cause_q;
    assign cpu_rdata = sel_buf_q ? mem_rdata : reg_q;

    // R4: end-of-packet raises the interrupt on the next cycle
    a_r4_eop_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        eop_evt |=> irq);

    // R4: reading the cause register clears it unless a new packet ends
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cause && !eop_evt) |=> !irq);
endmodule

// File: rtl/rx_pkt_buffer.sv
// Module rx_pkt_buffer
// Top of the receive packet buffer. It joins the link write side, the
// packet memory and the processor port. cfg_drop selects discard (1) or
// flow control (0) for packets that arrive while the buffer is held.
// Assumes a single clock domain shared by the link and the processor port.
module rx_pkt_buffer
    import rxpb_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 2048,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DROP_W    = 16,
    localparam int unsigned WORDS    = BUF_BYTES / 2,
    localparam int unsigned WPTR_W   = $clog2(WORDS),
    localparam int unsigned BYTE_W   = $clog2(WORDS + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lnk_vld,
    input  logic              lnk_first,
    input  logic              lnk_last,
    input  logic              lnk_odd,
    input  logic [15:0]       lnk_data,
    output logic              lnk_hold,
    input  logic              cfg_drop,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    output logic              irq
);
    logic              mem_we, mem_re, eop_evt, held, rel_req;
    logic [WPTR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [BYTE_W-1:0] byte_cnt;
    logic [DROP_W-1:0] drop_cnt;

    rxpb_frame #(
        .BUF_BYTES (BUF_BYTES),
        .DROP_W    (DROP_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .lnk_vld   (lnk_vld),
        .lnk_first (lnk_first),
        .lnk_last  (lnk_last),
        .lnk_odd   (lnk_odd),
        .lnk_data  (lnk_data),
        .drop_en   (cfg_drop),
        .rel_req   (rel_req),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .eop_evt   (eop_evt),
        .held      (held),
        .hold      (lnk_hold),
        .byte_cnt  (byte_cnt),
        .drop_cnt  (drop_cnt)
    );

    rxpb_store #(
        .DEPTH (WORDS),
        .DW    (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    rxpb_cpu_port #(
        .BUF_BYTES (BUF_BYTES),
        .ADDR_W    (ADDR_W),
        .DROP_W    (DROP_W)
    ) u_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .eop_evt   (eop_evt),
        .held      (held),
        .byte_cnt  (byte_cnt),
        .drop_cnt  (drop_cnt),
        .mem_rdata (mem_rdata),
        .mem_re    (mem_re),
        .mem_raddr (mem_raddr),
        .rel_req   (rel_req),
        .irq       (irq),
        .cpu_rdata (cpu_rdata)
    );

    // R6: in flow-control mode the hold appears only while a packet is parked
    a_r6_hold_only_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_hold |-> (held && !cfg_drop));

    // R7: discard mode never stalls the link
    a_r7_no_hold_in_discard: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_drop |-> !lnk_hold);
endmodule

// File: tb/test_rx_pkt_buffer.sv
// Bench for rx_pkt_buffer. A behavioural model (plain arrays and integers)
// is stepped at every clock edge and compared with irq, lnk_hold and the
// read data; directed reads add literal expectations per requirement.
module test_rx_pkt_buffer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lnk_vld = 1'b0, lnk_first = 1'b0, lnk_last = 1'b0, lnk_odd = 1'b0;
    logic [15:0] lnk_data = '0;
    logic        lnk_hold;
    logic        cfg_drop = 1'b0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    rx_pkt_buffer i_rx_pkt_buffer (
        .clk(clk), .rst_n(rst_n),
        .lnk_vld(lnk_vld), .lnk_first(lnk_first), .lnk_last(lnk_last),
        .lnk_odd(lnk_odd), .lnk_data(lnk_data), .lnk_hold(lnk_hold),
        .cfg_drop(cfg_drop), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    logic [15:0] m_mem [0:1023];
    int m_state, m_cnt, m_bytes, m_drops;
    bit m_trunc, m_dropping, m_cause, m_pend;
    logic [15:0] m_exp;

    function automatic logic [15:0] model_read(input logic [11:0] a);
        if (a < 12'h800)       return m_mem[a >> 1];
        else if (a == 12'h9E4) return 16'(m_bytes);
        else if (a == 12'h9E6) return 16'(m_drops & 16'hFFFF);
        else if (a == 12'h9E8) return (m_state == 2) ? 16'd1 : 16'd0;
        else if (a == 12'h9F0) return m_cause ? 16'd1 : 16'd0;
        else                   return 16'd0;
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        if (a < 12'h800)       return "R2";
        else if (a == 12'h9E4) return "R3";
        else if (a == 12'h9E6) return "R8";
        else if (a == 12'h9E8) return "R5";
        else if (a == 12'h9F0) return "R4";
        else                   return "R11";
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    logic [11:0] m_paddr;

    // Step the model at each edge, then compare once the design has settled.
    always @(posedge clk) begin
        bit eop, rel;
        int old;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_bytes = 0; m_drops = 0;
            m_trunc = 0; m_dropping = 0; m_cause = 0; m_pend = 0;
        end else begin
            eop = 0;
            old = m_state;
            m_pend = cpu_rd;
            m_paddr = cpu_addr;
            if (cpu_rd) m_exp = model_read(cpu_addr);
            if (cpu_rd && cpu_addr == 12'h9F0) m_cause = 0;
            rel = cpu_wr && cpu_addr == 12'h9F2 && cpu_wdata == 16'h0001;
            if (lnk_vld) begin
                if (m_dropping) begin
                    if (lnk_last) m_dropping = 0;
                end else if ((old == 0 && lnk_first) || old == 1) begin
                    if (old == 0) begin m_cnt = 0; m_trunc = 0; end
                    if (m_cnt < 1024) m_mem[m_cnt] = lnk_data;
                    else m_trunc = 1;
                    m_cnt++;
                    if (lnk_last) begin
                        m_bytes = m_trunc ? 2048 : (2 * m_cnt - int'(lnk_odd));
                        m_state = 2;
                        eop = 1;
                    end else begin
                        m_state = 1;
                    end
                end else if (old == 2 && cfg_drop && lnk_first) begin
                    m_drops++;
                    if (!lnk_last) m_dropping = 1;
                end
            end
            if (rel && old == 2) m_state = 0;
            if (eop) m_cause = 1;
        end
        #1;
        check(irq === m_cause, "R4", int'(irq), int'(m_cause));
        check(lnk_hold === (m_state == 2 && !cfg_drop), "R6", int'(lnk_hold),
              int'(m_state == 2 && !cfg_drop));
        if (rst_n && m_pend)
            check(cpu_rdata === m_exp, tag_of(m_paddr), int'(cpu_rdata), int'(m_exp));
    end

    // ---------------- stimulus tasks ----------------
    task automatic send_pkt(input int n, input logic [15:0] base, input bit odd);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lnk_vld   = 1'b1;
            lnk_data  = base + 16'(i);
            lnk_first = (i == 0);
            lnk_last  = (i == n - 1);
            lnk_odd   = (i == n - 1) && odd;
        end
        @(negedge clk);
        lnk_vld = 1'b0; lnk_first = 1'b0; lnk_last = 1'b0; lnk_odd = 1'b0;
    endtask

    task automatic cpu_write(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic expect_read(input logic [11:0] a, input logic [15:0] v, input string req);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_rd = 1'b0;
        check(cpu_rdata === v, req, int'(cpu_rdata), int'(v));
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(irq === 1'b0 && lnk_hold === 1'b0, "R1", int'(irq), 0);
        expect_read(12'h9E4, 16'd0, "R1");
        expect_read(12'h9E6, 16'd0, "R1");
        expect_read(12'h9E8, 16'd0, "R1");
        expect_read(12'h9F0, 16'd0, "R1");

        // R2/R3/R4/R6: an even four-word packet
        send_pkt(4, 16'h1000, 1'b0);
        check(irq === 1'b1, "R4", int'(irq), 1);
        expect_read(12'h9F0, 16'd1, "R4");
        expect_read(12'h9F0, 16'd0, "R4");
        check(irq === 1'b0, "R4", int'(irq), 0);
        expect_read(12'h000, 16'h1000, "R2");
        expect_read(12'h006, 16'h1003, "R2");
        expect_read(12'h007, 16'h1003, "R2");
        expect_read(12'h9E4, 16'd8, "R3");
        expect_read(12'h9E8, 16'd1, "R5");
        check(lnk_hold === 1'b1, "R6", int'(lnk_hold), 1);

        // R5: a wrong release value is ignored, the right one frees
        cpu_write(12'h9F2, 16'h0003);
        expect_read(12'h9E8, 16'd1, "R5");
        cpu_write(12'h9F2, 16'h0001);
        expect_read(12'h9E8, 16'd0, "R5");
        check(lnk_hold === 1'b0, "R6", int'(lnk_hold), 0);

        // R3: odd-length packets
        send_pkt(5, 16'h2000, 1'b1);
        expect_read(12'h9E4, 16'd9, "R3");
        cpu_write(12'h9F2, 16'h0001);
        send_pkt(1, 16'h2100, 1'b1);
        expect_read(12'h9E4, 16'd1, "R3");
        cpu_write(12'h9F2, 16'h0001);

        // R5: a release during the fill has no effect
        fork
            send_pkt(6, 16'h3000, 1'b0);
            begin repeat (2) @(negedge clk); cpu_write(12'h9F2, 16'h0001); end
        join
        expect_read(12'h9E8, 16'd1, "R5");
        expect_read(12'h9E4, 16'd12, "R5");
        expect_read(12'h00A, 16'h3005, "R2");

        // R7/R8: discard mode while held
        @(negedge clk) cfg_drop = 1'b1;
        @(negedge clk);
        check(lnk_hold === 1'b0, "R7", int'(lnk_hold), 0);
        send_pkt(3, 16'h4000, 1'b0);
        send_pkt(1, 16'h4100, 1'b0);
        expect_read(12'h9E6, 16'd2, "R8");
        expect_read(12'h9E4, 16'd12, "R7");
        expect_read(12'h000, 16'h3000, "R7");

        // R9: release in the middle of a dropped packet
        fork
            send_pkt(6, 16'h5000, 1'b0);
            begin repeat (3) @(negedge clk); cpu_write(12'h9F2, 16'h0001); end
        join
        expect_read(12'h9E8, 16'd0, "R9");
        expect_read(12'h9E6, 16'd3, "R8");
        send_pkt(2, 16'h5100, 1'b0);
        expect_read(12'h9E4, 16'd4, "R9");
        expect_read(12'h000, 16'h5100, "R9");
        cpu_write(12'h9F2, 16'h0001);

        // R10: oversize packet is truncated
        @(negedge clk) cfg_drop = 1'b0;
        send_pkt(1030, 16'h6000, 1'b0);
        expect_read(12'h9E4, 16'd2048, "R10");
        expect_read(12'h7FE, 16'h63FF, "R10");
        expect_read(12'h9F0, 16'd1, "R4");
        cpu_write(12'h9F2, 16'h0001);

        // R11: unmapped addresses
        expect_read(12'h900, 16'd0, "R11");
        expect_read(12'h9EA, 16'd0, "R11");
        expect_read(12'hFFE, 16'd0, "R11");

        repeat (3) @(negedge clk);
        summary();
    end
endmodule